// File: doc/BRIEF.md
# Stereo Serial PCM Output Formatter

This block turns pairs of 16-bit left and right PCM samples into a three-wire serial audio stream for an external converter. It runs from one master clock at 384 times the frame rate. From that clock it derives a bit clock at 32 times the frame rate and a word-select clock at the frame rate. It also drives a data line, an active-low mute line and a de-emphasis line. A configuration byte chooses the framing: standard or one-bit-delayed data, the word-select polarity, and which bit-clock edge bounds each data bit.

Each frame opens with a one-cycle sample-request pulse. The sample pair present at the clock edge that opens the frame is captured. If the source has no new pair at that edge, the previous pair is sent again. While mute is active, the frame carries zeros. Framing changes, mute changes and new samples take effect only where one frame ends and the next begins, so a frame is never built from mixed settings.

Top module: `pcm_serial_tx`

## Requirements
- R1: `mclk_o` follows `clk`. The bit clock has a period of 12 master cycles, and a frame is 32 bit periods (384 master cycles).
- R2: Within a frame, the first 16 bit slots carry the left sample and the last 16 carry the right sample, each MSB first.
- R3: When `cfg_fmt[2]` is 1, the data is delayed by one bit slot. Slot 0 then carries the LSB of the previous frame's right sample, and the MSB follows in slot 1. When `cfg_fmt[2]` is 0, the MSB is in slot 0.
- R4: When `cfg_fmt[1]` is 0, word select is low during the left half of the frame and high during the right half. When `cfg_fmt[1]` is 1, both levels are inverted.
- R5: When `cfg_fmt[0]` is 0, the bit clock is low for the first 6 master cycles of each slot and high for the last 6, so data changes on its falling edge. When `cfg_fmt[0]` is 1, the bit clock is inverted, so data changes on its rising edge.
- R6: Bits 7..3 of `cfg_fmt` have no effect. The format in force after reset is all zeros.
- R7: `mute_n` is low after reset. A `cmd_mute_on` pulse drives it low one cycle later, and a `cmd_mute_off` pulse alone drives it high; `cmd_mute_on` wins when both are high. A frame that opens while mute is active carries all-zero samples.
- R8: `deemph_o` follows `deemph_en` with one cycle of delay and is 0 after reset.
- R9: A `cfg_fmt` value applies only from the next frame start. Changing it mid-frame leaves the current frame unchanged.
- R10: `smp_req` is high for exactly one cycle: the first cycle of each frame, counting from the second frame after reset. The pair on `smp_left`/`smp_right` is captured at the edge that opens a frame if `smp_valid` is 1 at that edge.
- R11: If `smp_valid` is 0 at a frame start, the last captured pair is transmitted again. This includes a pair that was captured while muted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 384 x frame rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 8 | Format byte: bit2 delay, bit1 word-select invert, bit0 bit-clock invert |
| smp_left | input | SAMPLE_W | Left PCM sample |
| smp_right | input | SAMPLE_W | Right PCM sample |
| smp_valid | input | 1 | A new pair is present on the sample inputs |
| cmd_mute_on | input | 1 | Pulse: enable mute |
| cmd_mute_off | input | 1 | Pulse: release mute |
| deemph_en | input | 1 | De-emphasis request level |
| mclk_o | output | 1 | Master clock to the converter |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word-select clock |
| sdata_o | output | 1 | Serial data |
| smp_req | output | 1 | One-cycle pulse at each frame start |
| mute_n | output | 1 | Active-low mute to the converter |
| deemph_o | output | 1 | De-emphasis enable to the converter |

## Verification
The bench builds the block with its default values: a 16-bit sample width and a master-to-bit divider of 12. Every cycle of a captured frame can therefore be compared against the real 384:32:1 clock ratio. Because a frame lasts only 384 cycles, a long run of back-to-back frames fits in a short simulation. This allows the one-bit-delay case to be checked against the tail of the frame sent just before it, and a format change to be applied in the middle of a frame and observed at the next boundary.

// File: rtl/pcm_tx_pkg.sv
// Shared types for the serial PCM output formatter.
// Assumes the format byte carries its control bits in positions 2..0.
package pcm_tx_pkg;

    typedef struct packed {
        logic dly;      // one-slot data delay after word-select edge
        logic ws_inv;   // invert word select
        logic bck_inv;  // invert bit clock
    } fmt_t;

    // Pull the meaningful bits out of the format byte; upper bits are dropped.
    function automatic fmt_t decode_fmt(input logic [7:0] b);
        fmt_t f;
        f.dly     = b[2];
        f.ws_inv  = b[1];
        f.bck_inv = b[0];
        return f;
    endfunction

endpackage

// File: rtl/pcm_tx_timing.sv
// Master-clock divider: counts master cycles within a bit slot and slots
// within a frame, flags the last cycle of a frame, and raises a one-cycle
// request in the first cycle of each new frame.
// Assumes DIV >= 2 and SLOTS >= 2; counter widths are supplied by the parent.
module pcm_tx_timing #(
    parameter int DIV   = 12,
    parameter int SLOTS = 32,
    parameter int MW    = 4,
    parameter int SW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [MW-1:0] mcnt,
    output logic [SW-1:0] slot,
    output logic          wrap,
    output logic          req
);

    logic last_m;

    // Last master cycle of a slot, and of the frame.
    always_comb begin
        last_m = (mcnt == MW'(DIV - 1));
        wrap   = last_m && (slot == SW'(SLOTS - 1));
    end

    // Advance the cycle and slot counters; register the frame-start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcnt <= '0;
            slot <= '0;
            req  <= 1'b0;
        end else begin
            req <= wrap;
            if (last_m) begin
                mcnt <= '0;
                slot <= (slot == SW'(SLOTS - 1)) ? '0 : slot + SW'(1);
            end else begin
                mcnt <= mcnt + MW'(1);
            end
        end
    end

endmodule

// File: rtl/pcm_tx_ctrl.sv
// Converter control lines: mute state (set after reset, on-command wins)
// and a registered de-emphasis enable.
// Assumes the mute commands are single-cycle strobes.
module pcm_tx_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_mute_on,
    input  logic cmd_mute_off,
    input  logic deemph_en,
    output logic muted,
    output logic deemph_q
);

    // Track mute state from the command strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)            muted <= 1'b1;
        else if (cmd_mute_on)  muted <= 1'b1;
        else if (cmd_mute_off) muted <= 1'b0;
    end

    // Register the de-emphasis request for the output pin.
    always_ff @(posedge clk) begin
        if (!rst_n) deemph_q <= 1'b0;
        else        deemph_q <= deemph_en;
    end

endmodule

// File: rtl/pcm_tx_frame.sv
// Frame latch: at each frame boundary, captures the format, the sample pair
// (or reuses the held pair), applies mute, and keeps the LSB of the outgoing
// frame for the delayed-data format.
// Assumes wrap is high for exactly the last cycle of a frame.
module pcm_tx_frame
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wrap,
    input  logic [7:0]            cfg_fmt,
    input  logic [SAMPLE_W-1:0]   smp_left,
    input  logic [SAMPLE_W-1:0]   smp_right,
    input  logic                  smp_valid,
    input  logic                  muted,
    output logic [2*SAMPLE_W-1:0] word_q,
    output logic                  prev_lsb,
    output fmt_t                  fmt_q
);

    logic [2*SAMPLE_W-1:0] held_q;
    logic [2*SAMPLE_W-1:0] pick;

    // Choose the fresh pair when offered, else the held one.
    always_comb begin
        pick = smp_valid ? {smp_left, smp_right} : held_q;
    end

    // Load frame state at the boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q   <= '0;
            word_q   <= '0;
            prev_lsb <= 1'b0;
            fmt_q    <= '0;
        end else if (wrap) begin
            fmt_q    <= decode_fmt(cfg_fmt);
            prev_lsb <= word_q[0];
            held_q   <= pick;
            word_q   <= muted ? '0 : pick;
        end
    end

endmodule

// File: rtl/pcm_serial_tx.sv
// Stereo serial PCM output formatter: drives bit clock, word select and data
// from one master clock at a fixed 384:32:1 ratio (MCLK_DIV x 2*SAMPLE_W).
// Assumes 2*SAMPLE_W is a power of two and MCLK_DIV is even.
module pcm_serial_tx
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int MCLK_DIV = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          cfg_fmt,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                smp_valid,
    input  logic                cmd_mute_on,
    input  logic                cmd_mute_off,
    input  logic                deemph_en,
    output logic                mclk_o,
    output logic                bclk_o,
    output logic                ws_o,
    output logic                sdata_o,
    output logic                smp_req,
    output logic                mute_n,
    output logic                deemph_o
);

    localparam int SLOTS = 2 * SAMPLE_W;
    localparam int MW    = $clog2(MCLK_DIV);
    localparam int SW    = $clog2(SLOTS);
    localparam int HALF  = MCLK_DIV / 2;

    logic [MW-1:0]    mcnt;
    logic [SW-1:0]    slot;
    logic [SW-1:0]    idx;
    logic             wrap;
    logic             muted;
    logic             deemph_q;
    logic             prev_lsb;
    logic             bit_start;
    logic [SLOTS-1:0] tx_word;
    fmt_t             fmt_q;

    pcm_tx_timing #(.DIV(MCLK_DIV), .SLOTS(SLOTS), .MW(MW), .SW(SW)) u_timing (
        .clk(clk), .rst_n(rst_n), .mcnt(mcnt), .slot(slot),
        .wrap(wrap), .req(smp_req)
    );

    pcm_tx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_mute_on(cmd_mute_on),
        .cmd_mute_off(cmd_mute_off), .deemph_en(deemph_en),
        .muted(muted), .deemph_q(deemph_q)
    );

    pcm_tx_frame #(.SAMPLE_W(SAMPLE_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .cfg_fmt(cfg_fmt),
        .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
        .muted(muted), .word_q(tx_word), .prev_lsb(prev_lsb), .fmt_q(fmt_q)
    );

    // Clock and control pin decode from the frame counters.
    always_comb begin
        mclk_o    = clk;
        bit_start = (mcnt == '0);
        bclk_o    = (mcnt >= MW'(HALF)) ^ fmt_q.bck_inv;
        ws_o      = (slot >= SW'(SAMPLE_W)) ^ fmt_q.ws_inv;
        mute_n    = ~muted;
        deemph_o  = deemph_q;
    end

    // Serial bit select, optionally one slot late.
    always_comb begin
        if (fmt_q.dly) begin
            idx     = SW'(SLOTS - 1) - slot + SW'(1);
            sdata_o = (slot == '0) ? prev_lsb : tx_word[idx];
        end else begin
            idx     = SW'(SLOTS - 1) - slot;
            sdata_o = tx_word[idx];
        end
    end

endmodule

// File: rtl/pcm_serial_tx_chk.sv
// Temporal checks on the formatter, attached to the top module by bind.
module pcm_serial_tx_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_req,
    input logic              mute_n,
    input logic              cmd_mute_on,
    input logic              cmd_mute_off,
    input logic              deemph_en,
    input logic              deemph_o,
    input logic              ws_o,
    input logic              sdata_o,
    input logic              bit_start,
    input logic [WORD_W-1:0] tx_word
);

    // R10
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req |=> !smp_req);

    // R7
    mute_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_mute_on |=> !mute_n);

    // R7
    mute_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_mute_off && !cmd_mute_on) |=> mute_n);

    // R7
    mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_req && !$past(mute_n)) |-> (tx_word == '0));

    // R8
    deemph_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deemph_en |=> deemph_o);

    // R8
    deemph_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !deemph_en |=> !deemph_o);

    // R4
    ws_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_start |-> $stable(ws_o));

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_start |-> $stable(sdata_o));

endmodule

bind pcm_serial_tx pcm_serial_tx_chk #(.WORD_W(2 * SAMPLE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_req(smp_req), .mute_n(mute_n),
    .cmd_mute_on(cmd_mute_on), .cmd_mute_off(cmd_mute_off),
    .deemph_en(deemph_en), .deemph_o(deemph_o), .ws_o(ws_o),
    .sdata_o(sdata_o), .bit_start(bit_start), .tx_word(tx_word)
);

// File: tb/pcm_serial_tx_test.sv
module pcm_serial_tx_test;

    localparam int W   = 16;
    localparam int DIV = 12;
    localparam int FR  = 2 * W * DIV;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   cfg_fmt = 8'h00;
    logic [W-1:0] smp_left = '0;
    logic [W-1:0] smp_right = '0;
    logic         smp_valid = 1'b0;
    logic         cmd_mute_on = 1'b0;
    logic         cmd_mute_off = 1'b0;
    logic         deemph_en = 1'b0;
    logic         mclk_o, bclk_o, ws_o, sdata_o, smp_req, mute_n, deemph_o;

    int checks = 0;
    int errors = 0;
    logic [2*W-1:0] held = '0;
    logic [2*W-1:0] last_word = '0;
    bit exp_mute = 1'b1;

    always #5 clk = ~clk;

    pcm_serial_tx #(.SAMPLE_W(W), .MCLK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .smp_left(smp_left),
        .smp_right(smp_right), .smp_valid(smp_valid),
        .cmd_mute_on(cmd_mute_on), .cmd_mute_off(cmd_mute_off),
        .deemph_en(deemph_en), .mclk_o(mclk_o), .bclk_o(bclk_o),
        .ws_o(ws_o), .sdata_o(sdata_o), .smp_req(smp_req),
        .mute_n(mute_n), .deemph_o(deemph_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reset state of every output (R6, R7, R8, R10, R1)
    task automatic test_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check(mute_n == 1'b0, "R7", "mute_n after reset", 32'(mute_n), 0);
        check(deemph_o == 1'b0, "R8", "deemph after reset", 32'(deemph_o), 0);
        check(smp_req == 1'b0, "R10", "req after reset", 32'(smp_req), 0);
        check(ws_o == 1'b0 && bclk_o == 1'b0, "R6", "ws/bclk reset format",
              {30'd0, ws_o, bclk_o}, 0);
        check(mclk_o == 1'b0, "R1", "mclk low at negedge", 32'(mclk_o), 0);
    endtask

    // Mute release and de-emphasis follow (R7, R8)
    task automatic test_ctrl();
        cmd_mute_off = 1'b1;
        deemph_en = 1'b1;
        @(negedge clk);
        cmd_mute_off = 1'b0;
        exp_mute = 1'b0;
        check(mute_n == 1'b1, "R7", "mute_n after off cmd", 32'(mute_n), 1);
        check(deemph_o == 1'b1, "R8", "deemph follows", 32'(deemph_o), 1);
        deemph_en = 1'b0;
        @(negedge clk);
        check(deemph_o == 1'b0, "R8", "deemph clears", 32'(deemph_o), 0);
    endtask

    // Mute strobe; skips ahead to the end of a frame afterwards (R7)
    task automatic set_mute(input bit on);
        cmd_mute_on = on;
        cmd_mute_off = !on;
        @(negedge clk);
        cmd_mute_on = 1'b0;
        cmd_mute_off = 1'b0;
        exp_mute = on;
        check(mute_n == !on, "R7", "mute_n after strobe", 32'(mute_n), 32'(!on));
        while (!smp_req) @(negedge clk);
        repeat (FR - 1) @(negedge clk);
        last_word = exp_mute ? '0 : held;
    endtask

    // Drive one frame's inputs, then check every cycle of that frame.
    task automatic run_frame(input logic [7:0] fmt, input logic [W-1:0] l,
                             input logic [W-1:0] r, input bit vld,
                             input bit mid_chg, input logic [7:0] fmt_mid,
                             input string tag);
        logic [2*W-1:0] exp_w, got_s, exp_s;
        bit pb, pl, dl, eb, ew, ed;
        int nb, nw, nd, nr;
        cfg_fmt = fmt;
        smp_left = l;
        smp_right = r;
        smp_valid = vld;
        pb = fmt[0]; pl = fmt[1]; dl = fmt[2];
        exp_w = exp_mute ? '0 : (vld ? {l, r} : held);
        if (vld) held = {l, r};
        nb = 0; nw = 0; nd = 0; nr = 0;
        got_s = '0; exp_s = '0;
        @(negedge clk);
        while (!smp_req) @(negedge clk);
        smp_valid = 1'b0;
        for (int c = 0; c < FR; c++) begin
            int s, m;
            s = c / DIV;
            m = c % DIV;
            if (c > 0) @(negedge clk);
            if (mid_chg && c == FR / 2) cfg_fmt = fmt_mid;
            eb = (m >= DIV / 2) ^ pb;
            ew = (s >= W) ^ pl;
            if (dl) ed = (s == 0) ? last_word[0] : exp_w[2*W - s];
            else    ed = exp_w[2*W - 1 - s];
            if (bclk_o !== eb) nb++;
            if (ws_o !== ew) nw++;
            if (sdata_o !== ed) nd++;
            if (smp_req !== (c == 0)) nr++;
            if (m == DIV / 2) begin
                got_s[2*W - 1 - s] = sdata_o;
                exp_s[2*W - 1 - s] = ed;
            end
        end
        check(nb == 0, "R5", {tag, " bclk cycles wrong"}, 32'(nb), 0);
        check(nw == 0, "R4", {tag, " ws cycles wrong"}, 32'(nw), 0);
        check(nd == 0, "R2", {tag, " serial word"}, got_s, exp_s);
        check(nr == 0, "R10", {tag, " req cycles wrong"}, 32'(nr), 0);
        last_word = exp_w;
    endtask

    initial begin
        test_reset();
        test_ctrl();
        // R2 R4 R5: plain format
        run_frame(8'h00, 16'hA5C3, 16'h1234, 1'b1, 1'b0, 8'h00, "R2 normal");
        // R4: word-select inverted
        run_frame(8'h02, 16'h8001, 16'h7FFE, 1'b1, 1'b0, 8'h00, "R4 ws_inv");
        // R5: bit clock inverted
        run_frame(8'h01, 16'h0F0F, 16'hF0F1, 1'b1, 1'b0, 8'h00, "R5 bck_inv");
        // R3: delayed data, slot 0 holds prior right LSB (1)
        run_frame(8'h04, 16'hC001, 16'h5AA4, 1'b1, 1'b0, 8'h00, "R3 delay");
        // R11: no new pair, all format bits set
        run_frame(8'h07, 16'hDEAD, 16'hBEEF, 1'b0, 1'b0, 8'h00, "R11 repeat");
        // R6: upper format bits ignored
        run_frame(8'hF8, 16'h1357, 16'h2468, 1'b1, 1'b0, 8'h00, "R6 upper");
        // R9: mid-frame format change deferred
        run_frame(8'h00, 16'h6666, 16'h9999, 1'b1, 1'b1, 8'h06, "R9 mid");
        run_frame(8'h06, 16'h3C3C, 16'hC3C3, 1'b1, 1'b0, 8'h00, "R9 next");
        // R7: muted frame sends zeros but still captures the pair
        set_mute(1'b1);
        run_frame(8'h00, 16'hFFFF, 16'hABCD, 1'b1, 1'b0, 8'h00, "R7 muted");
        // R11: pair captured under mute replays after release
        set_mute(1'b0);
        run_frame(8'h00, 16'h0000, 16'h0000, 1'b0, 1'b0, 8'h00, "R11 unmute");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule